// File: doc/BRIEF.md
# Privileged Control Register File

This block keeps the processor's privileged control registers and serves the move-to and move-from accesses that software makes on them. Each access presents an index, a direction, write data, the current privilege level and the current operating mode. The block checks the access in the same cycle. A legal write takes effect on the next clock edge. A legal read returns data in the same cycle. An illegal access raises a one-cycle general-protection fault and changes nothing.

The operating-mode flags of register 0 and the page-table base held in register 3 are decoded continuously onto dedicated outputs. Page-walk, cache and interrupt logic use these outputs. Register 2 holds the faulting address. Register 4 holds the extension-enable flags. Register 8 holds a task-priority threshold.

Top module: `ctrl_reg_file`

## Requirements
- R1: After reset, register 0 reads 0x10 (only the extension-type bit is set). Registers 2, 3, 4 and 8 read zero, and every flag output and `pt_base` is zero.
- R2: An access, read or write, with `cur_priv` not equal to 0 raises `gp_fault`.
- R3: An access to index 1, 5, 6, 7 or 9 to 15 raises `gp_fault`.
- R4: Index 8 is reachable only in 64-bit mode, where `cur_mode` is 2'b10; in any other mode an access to it faults. Index 8 stores only its low `TPR_W` bits (default 4). Its other bits read as zero.
- R5: Modes 2'b00 (legacy), 2'b01 (compatibility) and 2'b11 (treated as legacy) are narrow modes. In a narrow mode a write changes only bits 31:0 and keeps bits 63:32. A read returns zero in bits 63:32. In 64-bit mode all 64 bits are read and written.
- R6: A 64-bit-mode write to index 0 or 4 with any of bits 63:32 nonzero faults.
- R7: A write to index 3 whose resulting value has any of bits 51:40 set faults. Bits 11:0 of register 3 always read zero. `pt_base` equals register 3.
- R8: Register 2 accepts any value without checks.
- R9: A write to index 0 whose resulting value has bit 31 (paging) set and bit 0 (protection) clear faults.
- R10: The flag outputs reflect register 0 at these bits: `page_en` at 31, `cache_dis` at 30, `no_wthru` at 29, `align_mask` at 18, `wr_prot` at 16, `num_err` at 5, `task_sw` at 3 and `prot_en` at 0.
- R11: Bit 4 of register 0 always reads 1, whatever is written to it.
- R12: `gp_fault` is high only in the cycle of a rejected access. `rd_data` is zero in that cycle, and after a write, and whenever `acc_valid` is low. A rejected write leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_index | input | 4 | Control register index |
| acc_wdata | input | 64 | Write data |
| cur_priv | input | 2 | Current privilege level |
| cur_mode | input | 2 | 00 legacy, 01 compatibility, 10 64-bit, 11 treated as legacy |
| rd_data | output | 64 | Read data, valid in the cycle of the read |
| gp_fault | output | 1 | General-protection fault pulse |
| page_en | output | 1 | Paging enable |
| prot_en | output | 1 | Protection enable |
| cache_dis | output | 1 | Cache disable |
| no_wthru | output | 1 | Not-write-through |
| align_mask | output | 1 | Alignment mask |
| wr_prot | output | 1 | Write protect |
| num_err | output | 1 | Numeric error |
| task_sw | output | 1 | Task switched |
| pt_base | output | 64 | Page-table base, 4 KiB aligned |

## Verification
The assertions check on every cycle the rules that do not depend on history:
- a nonzero privilege or index 8 outside 64-bit mode always faults;
- a fault zeroes the read data and freezes the flags and base;
- paging is never enabled without protection;
- the extension-type bit stays set;
- the reserved base bits stay clear;
- narrow reads carry a zero upper half.

The bench's scenarios are needed for the rest. These are the exact stored values and how narrow writes merge with the kept upper half. They also cover the effects of register 2 and register 8 and the sweep over every privilege, mode and index. The bench checks them against its own model of the registers.

// File: rtl/ctrl_reg_file.sv
module ctrl_reg_file #(
  parameter int TPR_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [3:0]  acc_index,
  input  logic [63:0] acc_wdata,
  input  logic [1:0]  cur_priv,
  input  logic [1:0]  cur_mode,
  output logic [63:0] rd_data,
  output logic        gp_fault,
  output logic        page_en,
  output logic        prot_en,
  output logic        cache_dis,
  output logic        no_wthru,
  output logic        align_mask,
  output logic        wr_prot,
  output logic        num_err,
  output logic        task_sw,
  output logic [63:0] pt_base
);
  localparam int XLEN = 64;
  localparam int HALF = XLEN / 2;
  localparam logic [XLEN-1:0] ET_BIT = 64'h10;

  logic [XLEN-1:0]  cr0_q, cr2_q, cr3_q, cr4_q;
  logic [TPR_W-1:0] cr8_q;
  logic [XLEN-1:0]  cur_val, eff;
  logic             idx_ok, wr_bad, commit;

  wire wide = (cur_mode == 2'b10);

  always_comb begin
    cur_val = '0;
    idx_ok  = 1'b1;
    case (acc_index)
      4'd0:    cur_val = cr0_q;
      4'd2:    cur_val = cr2_q;
      4'd3:    cur_val = cr3_q;
      4'd4:    cur_val = cr4_q;
      4'd8: begin
        cur_val[TPR_W-1:0] = cr8_q;
        idx_ok = wide;
      end
      default: idx_ok = 1'b0;
    endcase
  end

  assign eff = wide ? acc_wdata : {cur_val[XLEN-1:HALF], acc_wdata[HALF-1:0]};

  always_comb begin
    wr_bad = 1'b0;
    case (acc_index)
      4'd0:    wr_bad = (|eff[XLEN-1:HALF]) || (eff[31] && !eff[0]);
      4'd3:    wr_bad = |eff[51:40];
      4'd4:    wr_bad = |eff[XLEN-1:HALF];
      default: wr_bad = 1'b0;
    endcase
  end

  assign gp_fault = acc_valid && ((cur_priv != 2'd0) || !idx_ok || (acc_write && wr_bad));
  assign commit   = acc_valid && acc_write && !gp_fault;
  assign rd_data  = (acc_valid && !acc_write && !gp_fault)
                  ? (wide ? cur_val : {{HALF{1'b0}}, cur_val[HALF-1:0]}) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr0_q <= ET_BIT;
      cr2_q <= '0;
      cr3_q <= '0;
      cr4_q <= '0;
      cr8_q <= '0;
    end else if (commit) begin
      case (acc_index)
        4'd0:    cr0_q <= eff | ET_BIT;
        4'd2:    cr2_q <= eff;
        4'd3:    cr3_q <= {eff[XLEN-1:12], 12'b0};
        4'd4:    cr4_q <= eff;
        4'd8:    cr8_q <= eff[TPR_W-1:0];
        default: ;
      endcase
    end
  end

  assign page_en    = cr0_q[31];
  assign cache_dis  = cr0_q[30];
  assign no_wthru   = cr0_q[29];
  assign align_mask = cr0_q[18];
  assign wr_prot    = cr0_q[16];
  assign num_err    = cr0_q[5];
  assign task_sw    = cr0_q[3];
  assign prot_en    = cr0_q[0];
  assign pt_base    = cr3_q;
endmodule

// File: rtl/ctrl_reg_file_chk.sv
module ctrl_reg_file_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [3:0]  acc_index,
  input logic [1:0]  cur_priv,
  input logic [1:0]  cur_mode,
  input logic [63:0] rd_data,
  input logic        gp_fault,
  input logic        page_en,
  input logic        prot_en,
  input logic [63:0] pt_base,
  input logic [7:0]  flags,
  input logic [63:0] cr0_q
);
  p_priv_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && cur_priv != 2'd0) |-> gp_fault);

  p_cr8_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_index == 4'd8 && cur_mode != 2'b10) |-> gp_fault);

  p_narrow_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && cur_mode != 2'b10) |-> (rd_data[63:32] == 32'd0));

  p_base_rsvd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pt_base[51:40] == 12'd0);

  p_pg_needs_pe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    page_en |-> prot_en);

  p_et_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cr0_q[4]);

  p_fault_rd_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> (rd_data == 64'd0));

  p_fault_only_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !gp_fault);

  p_fault_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |=> ($stable(flags) && $stable(pt_base)));
endmodule

bind ctrl_reg_file ctrl_reg_file_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_index(acc_index), .cur_priv(cur_priv), .cur_mode(cur_mode),
  .rd_data(rd_data), .gp_fault(gp_fault), .page_en(page_en), .prot_en(prot_en),
  .pt_base(pt_base),
  .flags({page_en, cache_dis, no_wthru, align_mask, wr_prot, num_err, task_sw, prot_en}),
  .cr0_q(cr0_q)
);

// File: tb/tb_ctrl_reg_file.sv
module tb_ctrl_reg_file;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        acc_valid = 0, acc_write = 0;
  logic [3:0]  acc_index = 0;
  logic [63:0] acc_wdata = 0;
  logic [1:0]  cur_priv = 0, cur_mode = 0;
  logic [63:0] rd_data, pt_base;
  logic        gp_fault, page_en, prot_en, cache_dis, no_wthru, align_mask, wr_prot, num_err, task_sw;

  int n_chk = 0, n_fail = 0;
  logic [63:0] m0 = 64'h10, m2 = 0, m3 = 0, m4 = 0, m8 = 0;

  always #5 clk = ~clk;

  ctrl_reg_file dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mget(input logic [3:0] i);
    case (i)
      0: return m0; 2: return m2; 3: return m3; 4: return m4; 8: return m8;
      default: return 64'd0;
    endcase
  endfunction

  task automatic access(input logic w, input logic [3:0] i, input logic [63:0] d,
                        input logic [1:0] p, input logic [1:0] md);
    logic wide, ok, bad, ef;
    logic [63:0] e, er;
    string tag;
    wide = (md == 2'b10);
    ok = (i == 0 || i == 2 || i == 3 || i == 4 || (i == 8 && wide));
    e = wide ? d : {mget(i) >> 32, d[31:0]} ;
    e = wide ? d : ((mget(i) & 64'hFFFFFFFF_00000000) | {32'd0, d[31:0]});
    bad = 0;
    if (i == 0) bad = (e[63:32] != 0) || (e[31] && !e[0]);
    if (i == 4) bad = (e[63:32] != 0);
    if (i == 3) bad = (e[51:40] != 0);
    ef = (p != 0) || !ok || (w && bad);
    er = 0;
    if (!ef && !w) er = wide ? mget(i) : (mget(i) & 64'hFFFFFFFF);
    if (p != 0) tag = "R2";
    else if (i == 8 && !wide) tag = "R4";
    else if (!ok) tag = "R3";
    else if (!wide) tag = "R5";
    else if (i == 0) tag = (w && e[31] && !e[0]) ? "R9" : "R6";
    else if (i == 2) tag = "R8";
    else if (i == 3) tag = "R7";
    else if (i == 4) tag = "R6";
    else tag = "R4";
    @(negedge clk);
    acc_valid = 1; acc_write = w; acc_index = i; acc_wdata = d; cur_priv = p; cur_mode = md;
    #2;
    chk({tag, " fault R12"}, {63'd0, gp_fault}, {63'd0, ef});
    chk({tag, " rdata R12"}, rd_data, er);
    @(posedge clk);
    #1 acc_valid = 0;
    if (w && !ef) begin
      case (i)
        0: m0 = e | 64'h10;
        2: m2 = e;
        3: m3 = {e[63:12], 12'd0};
        4: m4 = e;
        8: m8 = {60'd0, e[3:0]};
        default: ;
      endcase
    end
    #2;
    chk("R10 flags", {56'd0, page_en, cache_dis, no_wthru, align_mask, wr_prot, num_err, task_sw, prot_en},
        {56'd0, m0[31], m0[30], m0[29], m0[18], m0[16], m0[5], m0[3], m0[0]});
    chk("R7 pt_base", pt_base, m3);
  endtask

  task automatic sweep_reads();
    for (int p = 0; p < 4; p++)
      for (int md = 0; md < 4; md++)
        for (int i = 0; i < 16; i++)
          access(0, 4'(i), 64'd0, 2'(p), 2'(md));
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #2;
    chk("R1 reset flags", {56'd0, page_en, cache_dis, no_wthru, align_mask, wr_prot, num_err, task_sw, prot_en}, 64'd0);
    chk("R1 reset base", pt_base, 64'd0);
    access(0, 0, 0, 0, 2);
    chk("R1 cr0 reset", m0, 64'h10);
    sweep_reads();

    access(1, 0, 64'h0000_0000_8000_0000, 0, 2);          // R9 fault
    access(1, 0, 64'h0000_0000_8000_0000, 0, 0);          // R9 narrow
    access(1, 0, 64'h0000_0000_E005_0029, 0, 2);          // R10 all flags
    access(1, 0, 64'h0000_0000_0000_0000, 0, 2);          // R11 clears but ET stays
    access(0, 0, 0, 0, 2);
    access(1, 0, 64'h0000_0001_0000_0001, 0, 2);          // R6 fault
    access(1, 0, 64'hFFFF_FFFF_6000_0008, 0, 1);          // R5 upper ignored
    access(1, 0, 64'h0000_0000_8000_0001, 3, 2);          // R2/R12 no change
    access(1, 4, 64'h8000_0000_0000_0000, 0, 2);          // R6 cr4
    access(1, 4, 64'h0000_0000_0000_06F0, 0, 2);
    access(1, 2, 64'hDEAD_BEEF_CAFE_F00D, 0, 2);          // R8
    access(1, 2, 64'h1234_5678_0000_0FFF, 0, 0);          // R5 keep upper
    access(0, 2, 0, 0, 2);
    access(0, 2, 0, 0, 3);
    access(1, 3, 64'h0000_0100_0000_0000, 0, 2);          // R7 reserved fault
    access(1, 3, 64'hFFF0_00FF_ABCD_EFFF, 0, 2);          // R7 low masked
    access(1, 3, 64'h0000_0000_1234_5FFF, 0, 1);
    access(1, 8, 64'h0000_0000_0000_00FF, 0, 1);          // R4 fault
    access(1, 8, 64'hFFFF_FFFF_FFFF_FFFB, 0, 2);          // R4 low bits only
    access(0, 8, 0, 0, 2);
    access(1, 1, 64'h1, 0, 2);                            // R3
    access(1, 8, 64'h5, 2, 2);                            // R2

    for (int md = 0; md < 4; md++)
      for (int i = 0; i < 16; i++) begin
        access(1, 4'(i), 64'h0000_0000_8001_0021 ^ (64'(i) << 12), 0, 2'(md));
        access(1, 4'(i), 64'h0000_0F00_0004_1001 | (64'(md) << 60), 0, 2'(md));
      end
    sweep_reads();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule